// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Peripheral Pin Sharing

This block manages a port of sixteen pads that can serve either as general-purpose I/O or as pins of on-chip peripherals. A small register bus reaches three registers. A function-select word gives each pad either to software or to its peripheral. A direction word decides whether a software-owned pad drives or listens. An output-value word holds the levels that driving pads put out.

A read of the data address does not return the stored output word. It returns the level seen on each pad after a two-flop synchronizer, so a pad that the port drives reads back its own value. A pad that is handed to a peripheral takes its drive value and its drive enable from that peripheral. The pad's input level is passed to the peripheral only while the peripheral owns the pad.

A typical loop-back setup makes the upper eight pads outputs and the lower eight inputs, with direction word 0xFF00. The software writes a word and then reads the pad levels.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset the function-select word and the direction word read as 0, and every pad output enable is 0.
- R2: For a pad whose function-select bit is 0, output enable equals its direction bit, where 1 means output. The pad output equals the stored output-value bit.
- R3: A write to the data address (2) updates the stored output bit only for pads whose direction bit is 1. Bits for input pads keep their previous value, which shows on the pad once it is later made an output.
- R4: A read of the data address returns the synchronized level of every pad, outputs included. With direction 0xFF00, the upper byte reads back the written value and the lower byte reads back the external levels.
- R5: For a pad whose function-select bit is 1, the pad output and output enable follow the peripheral's output and output-enable inputs, whatever the direction and stored output bits hold.
- R6: The peripheral input bit equals the pad level while the pad's function-select bit is 1, and reads 0 while it is 0.
- R7: A change on a pad input shows on the data read exactly two clock edges later, and not after one.
- R8: Address 0 reads back the function-select word, address 1 reads back the direction word, and address 3 reads 0. Writes to address 3 change nothing.
- R9: A write takes effect on the next clock edge and changes only the addressed register. With the write enable low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Register write enable |
| busAddr | input | 2 | Register address: 0 function select, 1 direction, 2 data |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for the addressed register, combinational |
| padIn | input | 16 | Level seen on each pad |
| padOut | output | 16 | Value driven onto each pad |
| padOe | output | 16 | Pad driver enable, 1 drives |
| perOut | input | 16 | Peripheral drive values |
| perOe | input | 16 | Peripheral drive enables |
| perIn | output | 16 | Pad levels passed to the peripherals |

## Verification
A wrong bit in the function-select or direction register shows on the pad enable and pad output in the cycle after the write, and can be read back at once. A corrupted stored output bit stays hidden while its pad is an input. It becomes visible only after the direction flips, which is why the bench writes data with pads set as inputs and then turns them into outputs. A fault in the synchronizer shows as a read that changes one edge too early or too late, so the bench samples on both sides of the second edge.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  typedef enum logic [1:0] {
    ADDR_SEL  = 2'd0,
    ADDR_DIR  = 2'd1,
    ADDR_DATA = 2'd2,
    ADDR_NONE = 2'd3
  } gpioAddr_t;

  typedef struct packed {
    logic      wrSel;
    logic      wrDir;
    logic      wrData;
    gpioAddr_t rdSel;
  } gpioStrobe_t;
endpackage

// File: rtl/gpio_mux_ctrl.sv
module gpio_mux_ctrl
  import gpio_mux_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic [1:0]  busAddr,
  output gpioStrobe_t strobe
);
  gpioAddr_t addrDec;

  always_comb begin
    addrDec       = gpioAddr_t'(busAddr);
    strobe.rdSel  = addrDec;
    strobe.wrSel  = busWrEn && (addrDec == ADDR_SEL);
    strobe.wrDir  = busWrEn && (addrDec == ADDR_DIR);
    strobe.wrData = busWrEn && (addrDec == ADDR_DATA);
  end

  // R9: at most one register strobed per cycle, none without write enable
  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrSel, strobe.wrDir, strobe.wrData}));
  assert_no_strobe_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |-> !(strobe.wrSel || strobe.wrDir || strobe.wrData));
endmodule

// File: rtl/gpio_mux_datapath.sv
module gpio_mux_datapath
  import gpio_mux_pkg::*;
#(
  parameter int PIN_COUNT = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  gpioStrobe_t          strobe,
  input  logic [PIN_COUNT-1:0] wrData,
  output logic [PIN_COUNT-1:0] rdData,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  input  logic [PIN_COUNT-1:0] perOut,
  input  logic [PIN_COUNT-1:0] perOe,
  output logic [PIN_COUNT-1:0] perIn
);
  localparam int SYNC_STAGES = 2;

  logic [PIN_COUNT-1:0] altSel;
  logic [PIN_COUNT-1:0] dirReg;
  logic [PIN_COUNT-1:0] outReg;
  logic [PIN_COUNT-1:0] syncStage [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      altSel <= '0;
      dirReg <= '0;
      outReg <= '0;
    end else begin
      if (strobe.wrSel)  altSel <= wrData;
      if (strobe.wrDir)  dirReg <= wrData;
      if (strobe.wrData) outReg <= (outReg & ~dirReg) | (wrData & dirReg);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncStage[s] <= '0;
    end else begin
      syncStage[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncStage[s] <= syncStage[s-1];
    end
  end

  for (genvar p = 0; p < PIN_COUNT; p++) begin : gPin
    always_comb begin
      padOut[p] = altSel[p] ? perOut[p] : outReg[p];
      padOe[p]  = altSel[p] ? perOe[p]  : dirReg[p];
      perIn[p]  = altSel[p] & padIn[p];
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      ADDR_SEL:  rdData = altSel;
      ADDR_DIR:  rdData = dirReg;
      ADDR_DATA: rdData = syncStage[SYNC_STAGES-1];
      default:   rdData = '0;
    endcase
  end

  logic [1:0] cyclesUp;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cyclesUp <= '0;
    else if (cyclesUp != 2'd3) cyclesUp <= cyclesUp + 2'd1;
  end

  // R3: a data write leaves the stored bits of input pads untouched
  assert_input_bits_kept_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrData |=> ((outReg & ~dirReg) == ($past(outReg) & ~$past(dirReg))));
  // R7: synchronized level lags the pad by exactly two edges
  assert_sync_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cyclesUp >= 2'd2) |-> (syncStage[SYNC_STAGES-1] == $past(padIn, 2)));
  // R9: no strobe, no register change
  assert_regs_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrSel || strobe.wrDir || strobe.wrData)
      |=> ($stable(altSel) && $stable(dirReg) && $stable(outReg)));
  // R1: one edge after reset release the port still owns no pad driver
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cyclesUp == 2'd0) |-> (altSel == '0 && dirReg == '0));
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int PIN_COUNT = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWrEn,
  input  logic [1:0]           busAddr,
  input  logic [PIN_COUNT-1:0] busWrData,
  output logic [PIN_COUNT-1:0] busRdData,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  input  logic [PIN_COUNT-1:0] perOut,
  input  logic [PIN_COUNT-1:0] perOe,
  output logic [PIN_COUNT-1:0] perIn
);
  gpioStrobe_t strobe;

  gpio_mux_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  gpio_mux_datapath #(.PIN_COUNT(PIN_COUNT)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (busWrData),
    .rdData (busRdData),
    .padIn  (padIn),
    .padOut (padOut),
    .padOe  (padOe),
    .perOut (perOut),
    .perOe  (perOe),
    .perIn  (perIn)
  );
endmodule

// File: tb/gpio_mux_port_tb.sv
module gpio_mux_port_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData, padIn, padOut, padOe, perIn;
  logic [15:0] perOut = '0, perOe = '0, extDrive = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [15:0] mSel = '0, mDir = '0, mOut = '0;

  always #2.5 clk = ~clk;

  // pad model: driven pads see the driven value, others the external level
  assign padIn = (padOe & padOut) | (~padOe & extDrive);

  gpio_mux_port u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .perOut(perOut), .perOe(perOe),
    .perIn(perIn)
  );

  function automatic logic [15:0] expOe();
    return (mSel & perOe) | (~mSel & mDir);
  endfunction
  function automatic logic [15:0] expOut();
    return (mSel & perOut) | (~mSel & mOut);
  endfunction
  function automatic logic [15:0] expPin();
    return (expOe() & expOut()) | (~expOe() & extDrive);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
    case (a)
      2'd0: mSel = d;
      2'd1: mDir = d;
      2'd2: mOut = (mOut & ~mDir) | (d & mDir);
      default: ;
    endcase
  endtask

  task automatic busRead(logic [1:0] a, output logic [15:0] d);
    busAddr = a;
    #0.5;
    d = busRdData;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic checkPads(string tag);
    #0.5;
    check({tag, " R2/R5 padOe"}, padOe, expOe());
    check({tag, " R2/R5 padOut"}, padOut, expOut());
    check({tag, " R6 perIn"}, perIn, mSel & padIn);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    busRead(2'd0, rd); check("R1 sel reset", rd, 16'h0);
    busRead(2'd1, rd); check("R1 dir reset", rd, 16'h0);
    check("R1 padOe reset", padOe, 16'h0);

    // R3: write data while all pads are inputs, then make them outputs
    busWrite(2'd2, 16'hA5A5);
    check("R3 padOut unchanged with inputs", padOut, 16'h0000);
    busWrite(2'd1, 16'hFFFF);
    #0.5; check("R3 stale bits after dir flip", padOut, 16'h0000);

    // R4 loop-back with direction 0xFF00
    busWrite(2'd1, 16'hFF00);
    extDrive = 16'h3C5A;
    busWrite(2'd2, 16'h96C3);
    check("R3 lower byte kept", padOut, 16'h9600);
    settle();
    busRead(2'd2, rd); check("R4 loopback read", rd, 16'h965A);

    // R7 exact sync latency with all pads inputs
    busWrite(2'd1, 16'h0000);
    extDrive = 16'h1111;
    settle();
    extDrive = 16'h8E21;
    @(negedge clk);
    busRead(2'd2, rd); check("R7 after one edge", rd, 16'h1111);
    @(negedge clk);
    busRead(2'd2, rd); check("R7 after two edges", rd, 16'h8E21);

    // R8 readback and reserved address
    busWrite(2'd3, 16'hFFFF);
    busRead(2'd3, rd); check("R8 addr3 zero", rd, 16'h0);
    busRead(2'd0, rd); check("R8 addr3 write no sel", rd, mSel);
    busRead(2'd1, rd); check("R8 addr3 write no dir", rd, mDir);

    // R5/R6 peripheral ownership
    perOut = 16'hF0F0; perOe = 16'hFF00;
    busWrite(2'd1, 16'h00FF);
    busWrite(2'd2, 16'h0F0F);
    busWrite(2'd0, 16'h0FF0);
    checkPads("directed");

    // R9 write-enable low: address changes with no write
    @(negedge clk);
    busAddr = 2'd0; busWrData = 16'hDEAD;
    @(negedge clk);
    busRead(2'd0, rd); check("R9 no write sel", rd, mSel);
    busRead(2'd1, rd); check("R9 no write dir", rd, mDir);

    for (int i = 0; i < 40; i++) begin
      perOut = 16'($urandom); perOe = 16'($urandom); extDrive = 16'($urandom);
      busWrite(2'($urandom_range(0, 3)), 16'($urandom));
      busWrite(2'd2, 16'($urandom));
      checkPads("random");
      busRead(2'd0, rd); check("R8 random sel", rd, mSel);
      busRead(2'd1, rd); check("R8 random dir", rd, mDir);
      settle();
      busRead(2'd2, rd); check("R4 random pins", rd, expPin());
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule